// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port. Software controls it through a small memory-mapped register bus. Software writes the values the pins drive and chooses, pin by pin, whether each pin is an output or an input. Every pad is sampled through a two-flop synchronizer, and software can always read the sampled level back.

Each pin has its own interrupt detector. Software sets it to fire on a low level, a high level, a rising edge or a falling edge. A separate per-pin control makes the pin fire on any transition instead. Detected events collect in a sticky pending register, which software clears by writing ones. A per-pin enable mask gates the pending bits onto three interrupt lines: one for the lower half of the pins, one for the upper half, and one for the whole port.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is held, and right after it, every readable register reads zero, `pad_oe` and `pad_out` are zero, and all three interrupt lines are low.
- R2: A write to offset 0x00 sets the value on `pad_out`. A write to offset 0x04 sets `pad_oe` (1 = drive the pin, 0 = input). Both registers read back what was written.
- R3: Offset 0x08 reads the pad levels seen two clock edges after they appear on `pad_in`, for output pins as well as input pins.
- R4: Each pin has a 2-bit trigger code. Pins 0 to 15 keep theirs in the register at offset 0x0C and pins 16 to 31 in the register at offset 0x10. For pin n the code sits at bits 2*(n mod 16)+1 down to 2*(n mod 16).
- R5: Code 0 flags a low level and code 1 flags a high level. The pending bit is set again on every cycle the level lasts, so a clear only sticks once the level has gone.
- R6: Code 2 flags a rising edge and code 3 flags a falling edge. An edge is a change between the synchronized level and its value one cycle earlier, and it is flagged once.
- R7: When a pin's bit in the register at offset 0x1C is 1, the pin flags both rising and falling edges, and its 2-bit code is ignored.
- R8: Pending flags read at offset 0x18. Writing 1 to bit n clears flag n and writing 0 leaves it unchanged. A detection in the same cycle as a clear keeps the flag set.
- R9: Mask register at offset 0x14, where 1 enables a pin. `irq_lo` is the OR of pending-and-enabled pins 0 to 15, `irq_hi` the OR for pins 16 to 31, and `irq_any` the OR for all 32 pins.
- R10: Reads from any other offset, including misaligned ones, return zero. Writes to offset 0x08 or to unused offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Values driven onto the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Interrupt for pins 0 to 15 |
| irq_hi | output | 1 | Interrupt for pins 16 to 31 |
| irq_any | output | 1 | Interrupt for the whole port |

## Verification
Directed steps put one pin at a time in each trigger mode. A held level must keep its flag set through a clear, while an edge must fire exactly once and only in its own direction. The timing of the rise on an edge-triggered pin is measured to the cycle, so a missing or extra synchronizer stage shows up. A both-edges pin is driven in the direction its 2-bit code would reject, which exposes an override that does not work. A pin in the lower half and a pin in the upper half with the same field position tell the two configuration registers apart, and masks on single pins in each half tell the two interrupt lines apart. Random pad flips, mixed with random writes to every offset (including the pad-status register and unused ones), are then compared cycle by cycle against a reference model written from the requirements.

// File: rtl/gpio_irq_pkg.sv
// gpio_irq_pkg
// Shared constants and types for the GPIO interrupt port: the register
// offsets on the bus, the trigger-code encoding and the register selector.
// Assumes byte addressing with 32-bit word registers.
package gpio_irq_pkg;

    localparam int OFS_W = 6;

    localparam logic [OFS_W-1:0] OFS_DATA   = 6'h00;
    localparam logic [OFS_W-1:0] OFS_DIR    = 6'h04;
    localparam logic [OFS_W-1:0] OFS_PAD    = 6'h08;
    localparam logic [OFS_W-1:0] OFS_CFG_LO = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_CFG_HI = 6'h10;
    localparam logic [OFS_W-1:0] OFS_MASK   = 6'h14;
    localparam logic [OFS_W-1:0] OFS_STAT   = 6'h18;
    localparam logic [OFS_W-1:0] OFS_BOTH   = 6'h1C;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_FALL = 2'd3
    } trig_e;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_DIR,
        SEL_PAD,
        SEL_CFG_LO,
        SEL_CFG_HI,
        SEL_MASK,
        SEL_STAT,
        SEL_BOTH
    } reg_sel_e;

    // Map a byte offset to a register; anything unmatched selects nothing.
    function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
        case (ofs)
            OFS_DATA:   return SEL_DATA;
            OFS_DIR:    return SEL_DIR;
            OFS_PAD:    return SEL_PAD;
            OFS_CFG_LO: return SEL_CFG_LO;
            OFS_CFG_HI: return SEL_CFG_HI;
            OFS_MASK:   return SEL_MASK;
            OFS_STAT:   return SEL_STAT;
            OFS_BOTH:   return SEL_BOTH;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
// gpio_sync
// Two-stage synchronizer for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no cross-bit coherence is promised.
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Sample the pads twice to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;

endmodule

// File: rtl/gpio_trig_detect.sv
// gpio_trig_detect
// Per-pin trigger evaluation. Combines the synchronized level, its value one
// cycle earlier, the 2-bit trigger code and the both-edge override into a
// one-cycle hit pulse (or a persistent hit for level modes).
// Assumes PINS is even; the lower half reads codes from cfg_lo and the upper
// half from cfg_hi, slot = pin mod (PINS/2).
module gpio_trig_detect
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic [PINS-1:0]       cur,
    input  logic [PINS-1:0]       prev,
    input  logic [2*(PINS/2)-1:0] cfg_lo,
    input  logic [2*(PINS/2)-1:0] cfg_hi,
    input  logic [PINS-1:0]       both,
    output logic [PINS-1:0]       hit
);

    localparam int HALF = PINS / 2;

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        localparam int SLOT = p % HALF;
        logic [1:0] code;
        logic       pin_hit;

        if (p < HALF) begin : g_lo
            assign code = cfg_lo[2*SLOT +: 2];
        end else begin : g_hi
            assign code = cfg_hi[2*SLOT +: 2];
        end

        // Pick the condition for this pin; the override beats the code.
        always_comb begin
            if (both[p]) begin
                pin_hit = cur[p] ^ prev[p];
            end else begin
                case (trig_e'(code))
                    TRIG_LOW:  pin_hit = ~cur[p];
                    TRIG_HIGH: pin_hit = cur[p];
                    TRIG_RISE: pin_hit = cur[p] & ~prev[p];
                    TRIG_FALL: pin_hit = ~cur[p] & prev[p];
                    default:   pin_hit = 1'b0;
                endcase
            end
        end

        assign hit[p] = pin_hit;
    end

endmodule

// File: rtl/gpio_irq_merge.sv
// gpio_irq_merge
// Sticky pending register with write-one-to-clear, and the masked
// interrupt reduction into lower-half, upper-half and whole-port lines.
// Assumes a hit in the same cycle as a clear wins, so no event is lost.
module gpio_irq_merge #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] hit,
    input  logic [PINS-1:0] clr,
    input  logic [PINS-1:0] mask,
    output logic [PINS-1:0] status,
    output logic            irq_lo,
    output logic            irq_hi,
    output logic            irq_any
);

    localparam int HALF = PINS / 2;

    logic [PINS-1:0] status_q;
    logic [PINS-1:0] active;

    // Hold pending flags: clear on request, then set from fresh hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr) | hit;
        end
    end

    // Gate pending flags by the enable mask and reduce per half.
    always_comb begin
        active  = status_q & mask;
        irq_lo  = |active[HALF-1:0];
        irq_hi  = |active[PINS-1:HALF];
        irq_any = irq_lo | irq_hi;
    end

    assign status = status_q;

endmodule

// File: rtl/gpio_irq_port.sv
// gpio_irq_port
// GPIO port with per-pin interrupt detection. Holds the output, direction,
// trigger-configuration, both-edge, and mask registers; synchronizes the
// pads; evaluates triggers; and drives three masked interrupt lines.
// Assumes a single-cycle register bus: writes land at the clock edge,
// reads are combinational in the access cycle. All state resets to zero.
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [OFS_W-1:0] bus_addr,
    input  logic [PINS-1:0]  bus_wdata,
    output logic [PINS-1:0]  bus_rdata,
    input  logic [PINS-1:0]  pad_in,
    output logic [PINS-1:0]  pad_out,
    output logic [PINS-1:0]  pad_oe,
    output logic             irq_lo,
    output logic             irq_hi,
    output logic             irq_any
);

    localparam int HALF  = PINS / 2;
    localparam int CFG_W = 2 * HALF;

    reg_sel_e        sel;
    logic            wr;
    logic [PINS-1:0] data_q;
    logic [PINS-1:0] dir_q;
    logic [CFG_W-1:0] cfg_lo_q;
    logic [CFG_W-1:0] cfg_hi_q;
    logic [PINS-1:0] mask_q;
    logic [PINS-1:0] both_q;
    logic [PINS-1:0] pad_sync;
    logic [PINS-1:0] prev_q;
    logic [PINS-1:0] hit;
    logic [PINS-1:0] clr;
    logic [PINS-1:0] status_q;

    assign sel = decode_ofs(bus_addr);
    assign wr  = bus_en & bus_we;

    // Update the writable control registers from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            dir_q    <= '0;
            cfg_lo_q <= '0;
            cfg_hi_q <= '0;
            mask_q   <= '0;
            both_q   <= '0;
        end else if (wr) begin
            case (sel)
                SEL_DATA:   data_q   <= bus_wdata;
                SEL_DIR:    dir_q    <= bus_wdata;
                SEL_CFG_LO: cfg_lo_q <= bus_wdata[CFG_W-1:0];
                SEL_CFG_HI: cfg_hi_q <= bus_wdata[CFG_W-1:0];
                SEL_MASK:   mask_q   <= bus_wdata;
                SEL_BOTH:   both_q   <= bus_wdata;
                default:    ;
            endcase
        end
    end

    gpio_sync #(.W(PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .d_sync  (pad_sync)
    );

    // Keep last cycle's synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= pad_sync;
        end
    end

    gpio_trig_detect #(.PINS(PINS)) u_detect (
        .cur    (pad_sync),
        .prev   (prev_q),
        .cfg_lo (cfg_lo_q),
        .cfg_hi (cfg_hi_q),
        .both   (both_q),
        .hit    (hit)
    );

    assign clr = (wr && sel == SEL_STAT) ? bus_wdata : '0;

    gpio_irq_merge #(.PINS(PINS)) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .clr     (clr),
        .mask    (mask_q),
        .status  (status_q),
        .irq_lo  (irq_lo),
        .irq_hi  (irq_hi),
        .irq_any (irq_any)
    );

    // Return the selected register; unused offsets read as zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            case (sel)
                SEL_DATA:   bus_rdata = data_q;
                SEL_DIR:    bus_rdata = dir_q;
                SEL_PAD:    bus_rdata = pad_sync;
                SEL_CFG_LO: bus_rdata[CFG_W-1:0] = cfg_lo_q;
                SEL_CFG_HI: bus_rdata[CFG_W-1:0] = cfg_hi_q;
                SEL_MASK:   bus_rdata = mask_q;
                SEL_STAT:   bus_rdata = status_q;
                SEL_BOTH:   bus_rdata = both_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign pad_out = data_q;
    assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_irq_port_chk.sv
// gpio_irq_port_chk
// Property checker for gpio_irq_port, attached with bind. Observes the bus,
// the pending register, the mask, the detector hits and the outputs.
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             bus_we,
    input logic [OFS_W-1:0] bus_addr,
    input logic [PINS-1:0]  bus_wdata,
    input logic [PINS-1:0]  pad_oe,
    input logic [PINS-1:0]  status_q,
    input logic [PINS-1:0]  mask_q,
    input logic [PINS-1:0]  hit,
    input logic             irq_any
);

    logic stat_wr;
    logic dir_wr;
    assign stat_wr = bus_en && bus_we && (bus_addr == OFS_STAT);
    assign dir_wr  = bus_en && bus_we && (bus_addr == OFS_DIR);

    // R8: a pending flag can only newly appear where the detector hit
    a_r8_set_only_by_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((status_q & ~$past(status_q) & ~$past(hit)) == '0));

    // R8: written ones clear the flag unless a hit arrived in the same cycle
    a_r8_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ((status_q & $past(bus_wdata) & ~$past(hit)) == '0));

    // R8: written zeros keep pending flags
    a_r8_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (($past(status_q) & ~$past(bus_wdata) & ~status_q) == '0));

    // R9: an interrupt needs a pending flag that is also enabled
    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |-> ((status_q & mask_q) != '0));

    // R9: everything masked keeps the port quiet
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_any);

    // R2: a direction write shows on the output enables one edge later
    a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> (pad_oe == $past(bus_wdata)));

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.PINS(PINS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_oe    (pad_oe),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .hit       (hit),
    .irq_any   (irq_any)
);

// File: tb/test_gpio_irq_port.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases, then seeded random traffic
// compared each cycle with a reference model built from the requirements.
module test_gpio_irq_port;
    import gpio_irq_pkg::*;

    localparam int PINS = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_en = 1'b0;
    logic             bus_we = 1'b0;
    logic [OFS_W-1:0] bus_addr = '0;
    logic [PINS-1:0]  bus_wdata = '0;
    logic [PINS-1:0]  bus_rdata;
    logic [PINS-1:0]  pad_in = '1;
    logic [PINS-1:0]  pad_out;
    logic [PINS-1:0]  pad_oe;
    logic             irq_lo, irq_hi, irq_any;

    always #2.5 clk = ~clk;

    gpio_irq_port #(.PINS(PINS)) i_gpio_irq_port (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_any(irq_any)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Trigger evaluation written from R4..R7 (code slot 2*(n mod 16)).
    function automatic logic [31:0] f_hit(input logic [31:0] cur, input logic [31:0] prv,
                                          input logic [31:0] cl, input logic [31:0] ch,
                                          input logic [31:0] bo);
        logic [31:0] h;
        h = '0;
        for (int p = 0; p < 32; p++) begin
            logic [1:0] c;
            c = (p < 16) ? cl[2*(p%16) +: 2] : ch[2*(p%16) +: 2];
            if (bo[p]) h[p] = cur[p] ^ prv[p];
            else begin
                case (c)
                    2'd0: h[p] = !cur[p];
                    2'd1: h[p] = cur[p];
                    2'd2: h[p] = cur[p] && !prv[p];
                    default: h[p] = !cur[p] && prv[p];
                endcase
            end
        end
        return h;
    endfunction

    // Reference model state
    logic [31:0] m_s1, m_s2, m_prev, m_status;
    logic [31:0] m_data, m_dir, m_cfgl, m_cfgh, m_mask, m_both;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_status <= '0;
            m_data <= '0; m_dir <= '0; m_cfgl <= '0; m_cfgh <= '0;
            m_mask <= '0; m_both <= '0;
        end else begin
            m_s1 <= pad_in;
            m_s2 <= m_s1;
            m_prev <= m_s2;
            m_status <= (m_status & ~((bus_en && bus_we && bus_addr == 6'h18) ? bus_wdata : 32'h0))
                        | f_hit(m_s2, m_prev, m_cfgl, m_cfgh, m_both);
            if (bus_en && bus_we) begin
                case (bus_addr)
                    6'h00: m_data <= bus_wdata;
                    6'h04: m_dir  <= bus_wdata;
                    6'h0C: m_cfgl <= bus_wdata;
                    6'h10: m_cfgh <= bus_wdata;
                    6'h14: m_mask <= bus_wdata;
                    6'h1C: m_both <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #0.1;
        v = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic stat_bit(input string req, input int b, input logic exp);
        logic [31:0] v;
        rd(6'h18, v);
        chk(req, $sformatf("status[%0d]", b), {31'b0, v[b]}, {31'b0, exp});
    endtask

    // Compare every register and output against the model.
    task automatic check_model();
        logic [31:0] v, act;
        rd(6'h00, v); chk("R2", "data reg", v, m_data);
        rd(6'h04, v); chk("R2", "dir reg", v, m_dir);
        rd(6'h08, v); chk("R3", "pad status", v, m_s2);
        rd(6'h0C, v); chk("R4", "cfg low", v, m_cfgl);
        rd(6'h10, v); chk("R4", "cfg high", v, m_cfgh);
        rd(6'h14, v); chk("R9", "mask", v, m_mask);
        rd(6'h18, v); chk("R8", "pending", v, m_status);
        rd(6'h1C, v); chk("R7", "both-edge reg", v, m_both);
        rd(6'h24, v); chk("R10", "unused read", v, 32'h0);
        chk("R2", "pad_out", pad_out, m_data);
        chk("R2", "pad_oe", pad_oe, m_dir);
        act = m_status & m_mask;
        chk("R9", "irq_lo", {31'b0, irq_lo}, {31'b0, |act[15:0]});
        chk("R9", "irq_hi", {31'b0, irq_hi}, {31'b0, |act[31:16]});
        chk("R9", "irq_any", {31'b0, irq_any}, {31'b0, |act});
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v0;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(6'(a * 4), v);
            chk("R1", $sformatf("reg @%0h in reset", a * 4), v, 32'h0);
        end
        chk("R1", "pad_oe in reset", pad_oe, 32'h0);
        chk("R1", "pad_out in reset", pad_out, 32'h0);
        chk("R1", "irq_any in reset", {31'b0, irq_any}, 32'h0);
        rst_n = 1'b1;
        idle(4);
        wr(6'h18, 32'hFFFF_FFFF);
        check_model();

        // R2: output data and direction
        wr(6'h00, 32'hA5A5_0F0F);
        wr(6'h04, 32'hFFFF_0000);
        chk("R2", "pad_out literal", pad_out, 32'hA5A5_0F0F);
        chk("R2", "pad_oe literal", pad_oe, 32'hFFFF_0000);

        // R3: pad status latency, output pins included
        pad_in = 32'h1234_5678;
        idle(1);
        rd(6'h08, v); chk("R3", "pad after 1 edge", v, 32'hFFFF_FFFF);
        idle(1);
        rd(6'h08, v); chk("R3", "pad after 2 edges", v, 32'h1234_5678);
        pad_in = '1;
        idle(3);
        wr(6'h18, 32'hFFFF_FFFF);
        check_model();

        // R4: field placement, pin 17 high level vs pin 1 low level
        wr(6'h10, 32'h0000_0004);
        idle(1);
        stat_bit("R4", 17, 1'b1);
        stat_bit("R4", 1, 1'b0);
        wr(6'h10, 32'h0);
        wr(6'h18, 32'hFFFF_FFFF);

        // R5: high level on pin 5 persists through a clear
        wr(6'h0C, 32'h1 << 10);
        idle(1);
        wr(6'h18, 32'h1 << 5);
        stat_bit("R5", 5, 1'b1);
        pad_in[5] = 1'b0;
        idle(3);
        wr(6'h18, 32'h1 << 5);
        stat_bit("R5", 5, 1'b0);

        // R6: rising on pin 3, exact latency and one-shot
        wr(6'h0C, (32'h1 << 10) | (32'h2 << 6));
        pad_in[3] = 1'b0;
        idle(3);
        wr(6'h18, 32'h1 << 3);
        stat_bit("R6", 3, 1'b0);
        pad_in[3] = 1'b1;
        idle(2);
        stat_bit("R6", 3, 1'b0);
        idle(1);
        stat_bit("R6", 3, 1'b1);
        wr(6'h18, 32'h1 << 3);
        idle(1);
        stat_bit("R6", 3, 1'b0);
        // R6: falling on pin 18
        wr(6'h10, 32'h3 << 4);
        pad_in[18] = 1'b0;
        idle(3);
        stat_bit("R6", 18, 1'b1);

        // R7: pin 20 both edges overrides a rising code
        wr(6'h10, (32'h3 << 4) | (32'h2 << 8));
        wr(6'h1C, 32'h1 << 20);
        wr(6'h18, 32'h0);
        check_model();
        pad_in[20] = 1'b0;
        idle(3);
        stat_bit("R7", 20, 1'b1);
        wr(6'h18, 32'h1 << 20);
        pad_in[20] = 1'b1;
        idle(3);
        stat_bit("R7", 20, 1'b1);

        // R8: writing zero keeps flags
        rd(6'h18, v0);
        wr(6'h18, 32'h0);
        rd(6'h18, v); chk("R8", "zero write keeps", v, v0);

        // R9: interrupt split
        wr(6'h14, 32'h1 << 20);
        chk("R9", "hi line pin20", {31'b0, irq_hi}, 32'h1);
        chk("R9", "lo line pin20", {31'b0, irq_lo}, 32'h0);
        chk("R9", "any line pin20", {31'b0, irq_any}, 32'h1);
        wr(6'h18, 32'hFFFF_FFFF);
        chk("R9", "any after clear", {31'b0, irq_any}, 32'h0);
        wr(6'h14, 32'h1 << 5);
        pad_in[5] = 1'b1;
        idle(3);
        chk("R9", "lo line pin5", {31'b0, irq_lo}, 32'h1);
        chk("R9", "hi line pin5", {31'b0, irq_hi}, 32'h0);

        // R10: ignored writes and unused reads
        wr(6'h08, 32'h0);
        rd(6'h08, v); chk("R10", "pad write ignored", v, pad_in);
        wr(6'h24, 32'hFFFF_FFFF);
        wr(6'h02, 32'hFFFF_FFFF);
        rd(6'h02, v); chk("R10", "misaligned read", v, 32'h0);
        check_model();

        // Random traffic
        for (int i = 0; i < 600; i++) begin
            int k;
            logic [5:0] a;
            @(negedge clk);
            check_model();
            if ($urandom_range(0, 9) == 0) pad_in = $urandom;
            else pad_in = pad_in ^ ($urandom & $urandom & $urandom);
            k = $urandom_range(0, 13);
            if (k < 10) begin
                case (k)
                    0: a = 6'h00; 1: a = 6'h04; 2: a = 6'h08; 3: a = 6'h0C;
                    4: a = 6'h10; 5: a = 6'h14; 6: a = 6'h18; 7: a = 6'h1C;
                    8: a = 6'h18; default: a = 6'h2C;
                endcase
                bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = $urandom;
            end else begin
                bus_en = 1'b0; bus_we = 1'b0;
            end
        end
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        @(negedge clk);
        check_model();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule